// File: doc/BRIEF.md
# Shifting Belt Operand Store

This block is the operand store of a minimal processor. It takes the place of a multi-ported register file. Values are held by position, not by name. Every new result enters at the top position. Each older value moves one place further from the top, and whatever sat in the last position is lost. There is no spill path and no mapping from names to positions. A value that slides off the end is gone for good.

An ALU built on this store always takes its first operand from the top position. The second operand comes from a single read port that spans the remaining positions and is steered by a small index. Index 1 means the value just below the top. Index 0 is folded onto position 1, so no index ever selects the top through the second port.

A build-time mode turns the store into a two-position ping-pong accumulator pair. Writing a new value moves the previous top into the second position. The second port then always returns that second position, whatever the index says. Reads are combinational from the stored state, so in a cycle that pushes, both outputs still show the values from before the push.

Top module: `belt_store`

## Requirements
- R1: A synchronous active-high reset clears every position to zero, and reset takes priority over a push in the same cycle. After reset, `top_q` and `pick_q` read 0 for every index.
- R2: A cycle with `push_en` high loads `push_data` into the top position. From the next cycle `top_q` shows that value.
- R3: In belt mode, a push moves every stored value one position away from the top in the same clock edge. Position k (1..DEPTH-1) then holds the value that was at position k-1.
- R4: In belt mode, the value in the last position (DEPTH-1) is lost on a push. After more than DEPTH pushes, only the last DEPTH pushed values can be read.
- R5: In belt mode, `sel_idx` = 0 selects position 1, exactly as `sel_idx` = 1 does. `sel_idx` = k for k in 1..DEPTH-1 selects position k.
- R6: Outputs are combinational from stored state. In a cycle with `push_en` high, `top_q` and `pick_q` show the values from before that push.
- R7: With `push_en` low, no position changes, whatever `push_data` carries.
- R8: In ping-pong mode the store has two positions. A push moves the former top into the second position, and `pick_q` returns the second position for every value of `sel_idx`.
- R9: In ping-pong mode, a value that was pushed two or more pushes ago can no longer be read from either output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| push_en | input | 1 | Push strobe: store `push_data` at the top and shift older values |
| push_data | input | DATA_W | Result to be pushed |
| sel_idx | input | $clog2(DEPTH) | Position index for the second operand (0 folds onto 1) |
| top_q | output | DATA_W | Value at the top position (first operand) |
| pick_q | output | DATA_W | Value at the indexed position (second operand) |

## Verification
The bench builds two copies side by side from the same stimulus. One uses the defaults (DATA_W 16, DEPTH 8, belt mode). The other uses the same widths in ping-pong mode. With the belt copy, the full index range can be swept, including the folded index 0 and the last position. Pushing more than eight values shows exactly where values drop off. The ping-pong copy shows that the index has no effect and that values are lost after two pushes.

// File: rtl/belt_pkg.sv
package belt_pkg;

    // Default geometry of the operand store
    localparam int DEF_DATA_W = 16;
    localparam int DEF_DEPTH  = 8;

    // Pair size used by the accumulator variant
    localparam int PAIR_DEPTH = 2;

    // Build-time organisation of the store
    typedef enum logic [0:0] {
        MODE_BELT     = 1'b0,
        MODE_PINGPONG = 1'b1
    } store_mode_e;

    // Number of positions actually built for a given mode
    function automatic int built_depth(store_mode_e mode, int depth);
        return (mode == MODE_PINGPONG) ? PAIR_DEPTH : depth;
    endfunction

endpackage

// File: rtl/belt_slots.sv
module belt_slots #(
    parameter int DATA_W = belt_pkg::DEF_DATA_W,
    parameter int N      = belt_pkg::DEF_DEPTH
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      push_en,
    input  logic [DATA_W-1:0]         push_data,
    output logic [N-1:0][DATA_W-1:0]  slots_q
);

    // One register per position; each takes its upper neighbour on a push
    for (genvar g = 0; g < N; g++) begin : g_slot
        if (g == 0) begin : g_top
            always_ff @(posedge clk) begin
                if (rst)
                    slots_q[g] <= '0;
                else if (push_en)
                    slots_q[g] <= push_data;
            end
        end else begin : g_lower
            always_ff @(posedge clk) begin
                if (rst)
                    slots_q[g] <= '0;
                else if (push_en)
                    slots_q[g] <= slots_q[g-1];
            end
        end
    end

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (slots_q == '0)); // R1

    AST_TOP_LOADED: assert property (@(posedge clk) disable iff (rst)
        push_en |=> (slots_q[0] == $past(push_data))); // R2

    AST_SHIFT_DOWN: assert property (@(posedge clk) disable iff (rst)
        push_en |=> (slots_q[N-1] == $past(slots_q[N-2]))); // R3

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !push_en |=> $stable(slots_q)); // R7

endmodule

// File: rtl/belt_pick.sv
module belt_pick #(
    parameter int                    DATA_W = belt_pkg::DEF_DATA_W,
    parameter int                    N      = belt_pkg::DEF_DEPTH,
    parameter int                    IDX_W  = 3,
    parameter belt_pkg::store_mode_e MODE   = belt_pkg::MODE_BELT
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [N-1:0][DATA_W-1:0]  slots_q,
    input  logic [IDX_W-1:0]          sel_idx,
    output logic [DATA_W-1:0]         pick_q
);

    logic [IDX_W-1:0] eff_idx;
    logic [IDX_W-1:0] pos_idx;

    // Index 0 would reach the top; fold it onto the position below it
    always_comb begin
        eff_idx = sel_idx;
        if (sel_idx == '0)
            eff_idx = IDX_W'(1);
    end

    // In the pair variant the index is ignored
    always_comb begin
        if (MODE == belt_pkg::MODE_PINGPONG)
            pos_idx = IDX_W'(1);
        else
            pos_idx = eff_idx;
    end

    // Single read port spanning the positions below the top
    always_comb begin
        pick_q = slots_q[1];
        for (int i = 0; i < N; i++) begin
            if (pos_idx == IDX_W'(i))
                pick_q = slots_q[i];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst && MODE == belt_pkg::MODE_BELT && sel_idx == '0)
            AST_ZERO_FOLDS: assert (pick_q == slots_q[1]); // R5
    end

    always_ff @(posedge clk) begin
        if (!rst && MODE == belt_pkg::MODE_PINGPONG)
            AST_PAIR_IGNORES_IDX: assert (pick_q == slots_q[1]); // R8
    end

endmodule

// File: rtl/belt_store.sv
module belt_store #(
    parameter int                    DATA_W = belt_pkg::DEF_DATA_W,
    parameter int                    DEPTH  = belt_pkg::DEF_DEPTH,
    parameter belt_pkg::store_mode_e MODE   = belt_pkg::MODE_BELT
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       push_en,
    input  logic [DATA_W-1:0]          push_data,
    input  logic [$clog2(DEPTH)-1:0]   sel_idx,
    output logic [DATA_W-1:0]          top_q,
    output logic [DATA_W-1:0]          pick_q
);

    localparam int IDX_W = $clog2(DEPTH);
    localparam int N     = belt_pkg::built_depth(MODE, DEPTH);

    logic [N-1:0][DATA_W-1:0] slots_q;

    belt_slots #(
        .DATA_W (DATA_W),
        .N      (N)
    ) u_slots (
        .clk       (clk),
        .rst       (rst),
        .push_en   (push_en),
        .push_data (push_data),
        .slots_q   (slots_q)
    );

    belt_pick #(
        .DATA_W (DATA_W),
        .N      (N),
        .IDX_W  (IDX_W),
        .MODE   (MODE)
    ) u_pick (
        .clk     (clk),
        .rst     (rst),
        .slots_q (slots_q),
        .sel_idx (sel_idx),
        .pick_q  (pick_q)
    );

    // First operand is always the top position
    assign top_q = slots_q[0];

    if (MODE == belt_pkg::MODE_PINGPONG) begin : g_pair_chk
        AST_PAIR_SWAP: assert property (@(posedge clk) disable iff (rst)
            push_en |=> (pick_q == $past(top_q))); // R8
    end else begin : g_belt_chk
        AST_TOP_TO_NEXT: assert property (@(posedge clk) disable iff (rst)
            (push_en && sel_idx == IDX_W'(1)) |=> (slots_q[1] == $past(top_q))); // R3
    end

endmodule

// File: tb/sim_belt_store.sv
module sim_belt_store;

    localparam int LPERIOD = 10;
    localparam int W       = 16;
    localparam int D       = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         push_en = 1'b0;
    logic [W-1:0] push_data = '0;
    logic [2:0]   sel_idx = '0;
    logic [W-1:0] top_b, pick_b, top_p, pick_p;

    int checks = 0;
    int errors = 0;

    logic [W-1:0] bm [D];
    logic [W-1:0] pm [2];

    belt_store #(.DATA_W(W), .DEPTH(D), .MODE(belt_pkg::MODE_BELT)) u0 (
        .clk(clk), .rst(rst), .push_en(push_en), .push_data(push_data),
        .sel_idx(sel_idx), .top_q(top_b), .pick_q(pick_b));

    belt_store #(.DATA_W(W), .DEPTH(D), .MODE(belt_pkg::MODE_PINGPONG)) u1 (
        .clk(clk), .rst(rst), .push_en(push_en), .push_data(push_data),
        .sel_idx(sel_idx), .top_q(top_p), .pick_q(pick_p));

    always #(LPERIOD/2) clk = ~clk;

    task automatic cmp(input string tag, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Drive one cycle, compare all outputs before the edge, then advance the model
    task automatic step(input logic r, input logic p, input logic [W-1:0] d,
                        input logic [2:0] ix, input string tag);
        int eff;
        string ptag;
        @(negedge clk);
        rst = r; push_en = p; push_data = d; sel_idx = ix;
        #1;
        eff  = (ix == 0) ? 1 : int'(ix);
        ptag = (tag == "R4") ? "R9" : "R8";
        cmp(tag,  "belt top",  top_b,  bm[0]);
        cmp(tag,  "belt pick", pick_b, bm[eff]);
        cmp(ptag, "pair top",  top_p,  pm[0]);
        cmp(ptag, "pair pick", pick_p, pm[1]);
        @(posedge clk);
        if (r) begin
            foreach (bm[i]) bm[i] = '0;
            pm[0] = '0; pm[1] = '0;
        end else if (p) begin
            for (int i = D-1; i > 0; i--) bm[i] = bm[i-1];
            bm[0] = d;
            pm[1] = pm[0];
            pm[0] = d;
        end
    endtask

    initial begin
        #(LPERIOD * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        foreach (bm[i]) bm[i] = '0;
        pm[0] = '0; pm[1] = '0;

        // R1: reset state, every index reads zero
        step(1'b1, 1'b0, '0, 3'd0, "R1");
        step(1'b1, 1'b0, '0, 3'd0, "R1");
        for (int i = 0; i < 8; i++) step(1'b0, 1'b0, 16'hBEEF, 3'(i), "R1");

        // R2: pushes land at the top
        for (int k = 1; k <= 3; k++) step(1'b0, 1'b1, 16'(16'h1000 + k * 16'h0111), 3'(k), "R2");
        step(1'b0, 1'b0, '0, 3'd1, "R2");

        // R6: pushing cycles still show pre-push values
        for (int k = 0; k < 4; k++) step(1'b0, 1'b1, 16'(16'h2A00 + k), 3'(k + 1), "R6");

        // R7: data bus ignored without a push
        for (int i = 1; i < 8; i++) step(1'b0, 1'b0, 16'hFFFF, 3'(i), "R7");

        // R5: index 0 folds onto position 1
        step(1'b0, 1'b0, '0, 3'd0, "R5");
        step(1'b0, 1'b1, 16'h5A5A, 3'd0, "R5");
        step(1'b0, 1'b0, '0, 3'd0, "R5");

        // R3: distinct patterns, then a full sweep
        step(1'b0, 1'b1, 16'hAAAA, 3'd2, "R3");
        step(1'b0, 1'b1, 16'h5555, 3'd3, "R3");
        step(1'b0, 1'b1, 16'h0000, 3'd4, "R3");
        step(1'b0, 1'b1, 16'hFFFF, 3'd5, "R3");
        for (int i = 1; i < 8; i++) step(1'b0, 1'b0, '0, 3'(i), "R3");

        // R4 / R9: overflow the belt, only the newest eight survive
        for (int k = 0; k < 11; k++) step(1'b0, 1'b1, 16'(16'hC000 + k * 16'h0101), 3'd7, "R4");
        for (int i = 0; i < 8; i++) step(1'b0, 1'b0, '0, 3'(i), "R4");

        // R1: reset wins over a simultaneous push
        step(1'b1, 1'b1, 16'h7777, 3'd1, "R1");
        for (int i = 1; i < 8; i++) step(1'b0, 1'b0, '0, 3'(i), "R1");

        // R8: pair alternation with index sweep
        for (int k = 0; k < 4; k++) step(1'b0, 1'b1, 16'(16'h0E00 + k), 3'(k * 2), "R8");
        for (int i = 0; i < 8; i++) step(1'b0, 1'b0, '0, 3'(i), "R8");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule